// File: doc/BRIEF.md
# Interrupt Controller Host Command Interface

This block is the byte-wide host side of an eight-line interrupt controller. Two addresses are visible to the host. Address 0 takes the first initialization word and the run-time commands. Address 1 takes the remaining initialization words and, once initialization has finished, the line mask. The block walks through the initialization word sequence, skipping steps according to the single-controller flag and the flag that asks for a final mode word. It holds the mode flags, the vector base, the mask, the rotation base, the read-select flag, the special-mask flag and the poll request.

Run-time command bytes are split by their bit fields into end-of-interrupt, rotation and read-control operations. End-of-interrupt operations leave the block as a one-hot clear strobe towards the in-service register, which sits outside this block. The priority resolver is also outside. It supplies the winning pending line and the highest-priority in-service line. A poll read returns the winning line and acknowledges it.

The host interface has no back-pressure. A single-cycle write strobe or read strobe is always accepted in the cycle it is presented. Read data is registered and appears one cycle after the read strobe. It holds until the next read.

Top module: `pic_cmd_if`

## Requirements
- R1: After reset the mask, rotation base, vector base, all mode flags, busy flag and read data are 0, and the block is ready for mask writes.
- R2: A write to address 0 with bit 4 set pulses `init_clr_o` in the same cycle. From the next cycle, the following are cleared: mask, rotation base, vector base, special fully nested flag, auto-EOI flag, rotate-on-auto-EOI flag, special-mask flag, read-select (back to pending) and poll. `single_o` takes bit 1 of the word, bit 0 is kept as the mode-word-needed flag, and `init_busy_o` goes to 1.
- R3: In the vector step, a write to address 1 stores the byte with bits 2:0 cleared as `vec_base_o`. With the single flag set, the sequence then goes to the mode step if a mode word is needed, and otherwise ends.
- R4: Without the single flag, the vector step is followed by a cascade step. A write there goes to the mode step if a mode word is needed, and otherwise ends. In the mode step, bit 4 sets `sfnm_o`, bit 1 sets `aeoi_o`, and the sequence ends. `init_busy_o` is 1 exactly while a sequence is unfinished.
- R5: A write to address 1 loads `mask_o` only when no sequence is in progress. Other writes leave the mask unchanged.
- R6: A write to address 0 with bit 4 = 0 and bit 3 = 1 is a read-control command. Bit 2 = 1 requests poll. Bit 1 = 1 copies bit 0 into read-select (1 selects in-service). Bit 6 = 1 copies bit 5 into `spec_mask_o`. A cleared enable bit leaves its flag unchanged.
- R7: Operation commands are address-0 writes with bits 4 and 3 both 0. The opcode is bits 7:5. Opcodes 0 and 4 set `rot_aeoi_o` to bit 7.
- R8: Opcodes 1 and 5 are non-specific EOI. In the write cycle, `isr_clr_o` is one-hot at `top_isr_line_i` when `top_isr_vld_i` is 1, and zero otherwise. Opcode 5 with a valid line also sets the rotation base to that line plus 1, modulo 8.
- R9: Opcode 3 clears the in-service line given by bits 2:0. Opcode 7 does the same and also sets the rotation base to that line plus 1, modulo 8.
- R10: Opcode 6 sets the rotation base to bits 2:0 plus 1, modulo 8, with no clear strobe. The rotation base changes only on writes.
- R11: Opcode 2 has no effect on any output.
- R12: A read while poll is pending returns 0x80 OR `win_line_i` in the next cycle and pulses `ack_o` with `ack_line_o` in the read cycle. With no winner it returns 0 and gives no acknowledge. Either way, poll is cleared.
- R13: Any other read of address 0 returns the in-service input when read-select is 1, or the pending input when it is 0. A read of address 1 returns the mask. The data appears the cycle after the strobe and is held until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 1 | Host address select |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered read data |
| pend_i | input | 8 | Pending-line register contents |
| insvc_i | input | 8 | In-service register contents |
| win_vld_i | input | 1 | Resolver has a winning line |
| win_line_i | input | 3 | Winning line number |
| top_isr_vld_i | input | 1 | In-service register is non-empty |
| top_isr_line_i | input | 3 | Highest-priority in-service line |
| init_clr_o | output | 1 | Clear pulse for pending and in-service state |
| isr_clr_o | output | 8 | One-hot in-service clear strobe |
| ack_o | output | 1 | Poll acknowledge strobe |
| ack_line_o | output | 3 | Line acknowledged by poll |
| mask_o | output | 8 | Line mask |
| rot_base_o | output | 3 | Rotation base (lowest-priority successor) |
| vec_base_o | output | 8 | Vector base, bits 2:0 zero |
| single_o | output | 1 | Single-controller flag |
| sfnm_o | output | 1 | Special fully nested flag |
| aeoi_o | output | 1 | Auto-EOI flag |
| rot_aeoi_o | output | 1 | Rotate-on-auto-EOI flag |
| spec_mask_o | output | 1 | Special-mask flag |
| init_busy_o | output | 1 | Initialization sequence in progress |

## Verification
The assertions check the following on every cycle:
- the clear strobe is one-hot and comes only from an operation-command write;
- a non-specific EOI clears exactly the reported in-service line;
- an acknowledge comes only with a read and a winning line;
- mask, rotation base and busy flag move only on writes;
- the mask ignores writes during a sequence;
- an initialization pulse leaves mask and rotation cleared.

Only the directed scenarios can show the following:
- the step skipping for every combination of single and mode-word flags;
- the exact values stored for vector base and mode bits;
- the modulo-8 wrap of the rotation base;
- that a poll request is consumed by exactly one read;
- that an initialization word cancels a pending poll and read-select.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_VEC  = 2'd1,
    ST_CASC = 2'd2,
    ST_MODE = 2'd3
  } init_st_e;

  typedef enum logic [2:0] {
    OP_RAEOI_OFF  = 3'd0,
    OP_EOI_NS     = 3'd1,
    OP_NOP        = 3'd2,
    OP_EOI_SP     = 3'd3,
    OP_RAEOI_ON   = 3'd4,
    OP_EOI_NS_ROT = 3'd5,
    OP_SET_PRIO   = 3'd6,
    OP_EOI_SP_ROT = 3'd7
  } op_e;

  typedef struct packed {
    logic sfnm;
    logic aeoi;
    logic single;
    logic need_mode;
  } mode_t;

endpackage

// File: rtl/pic_init_fsm.sv
module pic_init_fsm
  import pic_cmd_pkg::*;
#(
  parameter int DW = 8,
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          ctl_wr,
  input  logic [DW-1:0] wdata,
  output init_st_e      st,
  output logic [DW-1:0] vec_base,
  output mode_t         mode
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_RUN;
      vec_base <= '0;
      mode     <= '0;
    end else if (start) begin
      st             <= ST_VEC;
      vec_base       <= '0;
      mode.sfnm      <= 1'b0;
      mode.aeoi      <= 1'b0;
      mode.single    <= wdata[1];
      mode.need_mode <= wdata[0];
    end else if (ctl_wr) begin
      unique case (st)
        ST_VEC: begin
          vec_base <= {wdata[DW-1:LW], {LW{1'b0}}};
          if (mode.single) st <= mode.need_mode ? ST_MODE : ST_RUN;
          else             st <= ST_CASC;
        end
        ST_CASC: st <= mode.need_mode ? ST_MODE : ST_RUN;
        ST_MODE: begin
          mode.sfnm <= wdata[4];
          mode.aeoi <= wdata[1];
          st        <= ST_RUN;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/pic_op_dec.sv
module pic_op_dec
  import pic_cmd_pkg::*;
#(
  parameter int NL = 8,
  localparam int LW = $clog2(NL)
) (
  input  logic          op_wr,
  input  logic [2:0]    op_code,
  input  logic [LW-1:0] op_line,
  input  logic          top_vld,
  input  logic [LW-1:0] top_line,
  output logic [NL-1:0] clr,
  output logic          rot_ld,
  output logic [LW-1:0] rot_val,
  output logic          raeoi_ld,
  output logic          raeoi_val
);

  localparam logic [NL-1:0] ONE = {{(NL-1){1'b0}}, 1'b1};

  op_e op;
  assign op = op_e'(op_code);

  always_comb begin
    clr       = '0;
    rot_ld    = 1'b0;
    rot_val   = op_line + 1'b1;
    raeoi_ld  = 1'b0;
    raeoi_val = op_code[2];
    if (op_wr) begin
      unique case (op)
        OP_RAEOI_OFF, OP_RAEOI_ON: raeoi_ld = 1'b1;
        OP_EOI_NS, OP_EOI_NS_ROT: begin
          if (top_vld) begin
            clr     = ONE << top_line;
            rot_ld  = (op == OP_EOI_NS_ROT);
            rot_val = top_line + 1'b1;
          end
        end
        OP_EOI_SP:     clr = ONE << op_line;
        OP_SET_PRIO:   rot_ld = 1'b1;
        OP_EOI_SP_ROT: begin
          clr    = ONE << op_line;
          rot_ld = 1'b1;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/pic_rd_path.sv
module pic_rd_path #(
  parameter int DW = 8,
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd,
  input  logic          addr,
  input  logic          poll,
  input  logic          rd_isr,
  input  logic [DW-1:0] pend,
  input  logic [DW-1:0] insvc,
  input  logic [DW-1:0] mask,
  input  logic          win_vld,
  input  logic [LW-1:0] win_line,
  output logic [DW-1:0] rdata,
  output logic          ack
);

  assign ack = rd && poll && win_vld;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd) begin
      if (poll)       rdata <= win_vld ? {1'b1, {(DW-1-LW){1'b0}}, win_line} : '0;
      else if (!addr) rdata <= rd_isr ? insvc : pend;
      else            rdata <= mask;
    end
  end

endmodule

// File: rtl/pic_cmd_if.sv
module pic_cmd_if
  import pic_cmd_pkg::*;
#(
  parameter int NL = 8,
  localparam int LW = $clog2(NL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic          host_addr,
  input  logic [NL-1:0] host_wdata,
  output logic [NL-1:0] host_rdata,
  input  logic [NL-1:0] pend_i,
  input  logic [NL-1:0] insvc_i,
  input  logic          win_vld_i,
  input  logic [LW-1:0] win_line_i,
  input  logic          top_isr_vld_i,
  input  logic [LW-1:0] top_isr_line_i,
  output logic          init_clr_o,
  output logic [NL-1:0] isr_clr_o,
  output logic          ack_o,
  output logic [LW-1:0] ack_line_o,
  output logic [NL-1:0] mask_o,
  output logic [LW-1:0] rot_base_o,
  output logic [NL-1:0] vec_base_o,
  output logic          single_o,
  output logic          sfnm_o,
  output logic          aeoi_o,
  output logic          rot_aeoi_o,
  output logic          spec_mask_o,
  output logic          init_busy_o
);

  logic     start, rdcmd, op_wr, ctl_wr;
  logic     poll_q, rd_isr_q;
  logic     rot_ld, raeoi_ld, raeoi_val;
  logic [LW-1:0] rot_val;
  init_st_e st;
  mode_t    mode;

  assign ctl_wr = host_wr && host_addr;
  assign start  = host_wr && !host_addr && host_wdata[4];
  assign rdcmd  = host_wr && !host_addr && !host_wdata[4] && host_wdata[3];
  assign op_wr  = host_wr && !host_addr && !host_wdata[4] && !host_wdata[3];

  pic_init_fsm #(.DW(NL), .LW(LW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .ctl_wr(ctl_wr),
    .wdata(host_wdata), .st(st), .vec_base(vec_base_o), .mode(mode)
  );

  pic_op_dec #(.NL(NL)) u_dec (
    .op_wr(op_wr), .op_code(host_wdata[7:5]), .op_line(host_wdata[LW-1:0]),
    .top_vld(top_isr_vld_i), .top_line(top_isr_line_i),
    .clr(isr_clr_o), .rot_ld(rot_ld), .rot_val(rot_val),
    .raeoi_ld(raeoi_ld), .raeoi_val(raeoi_val)
  );

  pic_rd_path #(.DW(NL), .LW(LW)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd(host_rd), .addr(host_addr),
    .poll(poll_q), .rd_isr(rd_isr_q), .pend(pend_i), .insvc(insvc_i),
    .mask(mask_o), .win_vld(win_vld_i), .win_line(win_line_i),
    .rdata(host_rdata), .ack(ack_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || start) begin
      mask_o      <= '0;
      rot_base_o  <= '0;
      poll_q      <= 1'b0;
      rd_isr_q    <= 1'b0;
      spec_mask_o <= 1'b0;
      rot_aeoi_o  <= 1'b0;
    end else begin
      if (ctl_wr && st == ST_RUN) mask_o <= host_wdata;
      if (host_rd)  poll_q <= 1'b0;
      if (rdcmd) begin
        if (host_wdata[2]) poll_q      <= 1'b1;
        if (host_wdata[1]) rd_isr_q    <= host_wdata[0];
        if (host_wdata[6]) spec_mask_o <= host_wdata[5];
      end
      if (rot_ld)   rot_base_o <= rot_val;
      if (raeoi_ld) rot_aeoi_o <= raeoi_val;
    end
  end

  assign init_clr_o  = start;
  assign ack_line_o  = ack_o ? win_line_i : '0;
  assign single_o    = mode.single;
  assign sfnm_o      = mode.sfnm;
  assign aeoi_o      = mode.aeoi;
  assign init_busy_o = (st != ST_RUN);

endmodule

// File: rtl/pic_cmd_if_chk.sv
module pic_cmd_if_chk #(
  parameter int NL = 8,
  localparam int LW = $clog2(NL)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          host_wr,
  input logic          host_rd,
  input logic          host_addr,
  input logic [NL-1:0] host_wdata,
  input logic          win_vld_i,
  input logic [LW-1:0] win_line_i,
  input logic          top_isr_vld_i,
  input logic [LW-1:0] top_isr_line_i,
  input logic          init_clr_o,
  input logic [NL-1:0] isr_clr_o,
  input logic          ack_o,
  input logic [LW-1:0] ack_line_o,
  input logic [NL-1:0] mask_o,
  input logic [LW-1:0] rot_base_o,
  input logic          init_busy_o
);

  p_init_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    init_clr_o |=> (init_busy_o && mask_o == '0 && rot_base_o == '0));

  p_busy_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !host_wr |=> $stable(init_busy_o));

  p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !host_wr |=> $stable(mask_o));

  p_mask_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr && init_busy_o) |=> $stable(mask_o));

  p_ns_eoi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !host_addr && host_wdata[4:3] == 2'b00 && host_wdata[6:5] == 2'b01
     && top_isr_vld_i) |-> (isr_clr_o == ({{(NL-1){1'b0}}, 1'b1} << top_isr_line_i)));

  p_clr_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|isr_clr_o) |-> (host_wr && !host_addr && host_wdata[4:3] == 2'b00));

  p_clr_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(isr_clr_o));

  p_rot_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !host_wr |=> $stable(rot_base_o));

  p_ack_src_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ack_o |-> (host_rd && win_vld_i && ack_line_o == win_line_i));

endmodule

bind pic_cmd_if pic_cmd_if_chk #(.NL(NL)) u_chk (.*);

// File: tb/pic_cmd_if_tb.sv
module pic_cmd_if_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 1'b0, host_rd = 1'b0, host_addr = 1'b0;
  logic [7:0] host_wdata = '0, host_rdata;
  logic [7:0] pend_i = '0, insvc_i = '0;
  logic       win_vld_i = 1'b0, top_isr_vld_i = 1'b0;
  logic [2:0] win_line_i = '0, top_isr_line_i = '0;
  logic       init_clr_o, ack_o, single_o, sfnm_o, aeoi_o, rot_aeoi_o, spec_mask_o, init_busy_o;
  logic [7:0] isr_clr_o, mask_o, vec_base_o;
  logic [2:0] ack_line_o, rot_base_o;

  int   n_chk = 0, n_fail = 0, cyc = 0;
  logic done = 1'b0;
  logic [7:0] cap_clr, cap_rd;
  logic       cap_init, cap_ack;
  logic [2:0] cap_line;

  always #5 clk = ~clk;

  pic_cmd_if dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); host_wr = 1'b1; host_addr = a; host_wdata = d;
    #1; cap_clr = isr_clr_o; cap_init = init_clr_o;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic rd(input logic a);
    @(negedge clk); host_rd = 1'b1; host_addr = a;
    #1; cap_ack = ack_o; cap_line = ack_line_o;
    @(negedge clk); host_rd = 1'b0; cap_rd = host_rdata;
  endtask

  task automatic t_reset;
    chk("R1 mask", 32'(mask_o), 0);
    chk("R1 rot", 32'(rot_base_o), 0);
    chk("R1 vec", 32'(vec_base_o), 0);
    chk("R1 flags", 32'({single_o, sfnm_o, aeoi_o, rot_aeoi_o, spec_mask_o, init_busy_o}), 0);
    chk("R1 rdata", 32'(host_rdata), 0);
  endtask

  task automatic t_mask_and_reads;
    wr(1, 8'hA5);
    chk("R5 mask load", 32'(mask_o), 32'hA5);
    pend_i = 8'h81; insvc_i = 8'h42;
    rd(1); chk("R13 mask read", 32'(cap_rd), 32'hA5);
    rd(0); chk("R13 pending read", 32'(cap_rd), 32'h81);
    wr(0, 8'h0B); rd(0); chk("R6 select in-service", 32'(cap_rd), 32'h42);
    wr(0, 8'h09); rd(0); chk("R6 select kept", 32'(cap_rd), 32'h42);
    wr(0, 8'h0A); rd(0); chk("R6 select pending", 32'(cap_rd), 32'h81);
    pend_i = 8'h11;
    @(negedge clk); chk("R13 data held", 32'(host_rdata), 32'h81);
    pend_i = 8'h81;
  endtask

  task automatic t_spec_mask;
    wr(0, 8'h68); chk("R6 spec mask set", 32'(spec_mask_o), 1);
    wr(0, 8'h28); chk("R6 spec mask kept", 32'(spec_mask_o), 1);
    wr(0, 8'h48); chk("R6 spec mask clr", 32'(spec_mask_o), 0);
  endtask

  task automatic t_poll;
    win_vld_i = 1'b1; win_line_i = 3'd5;
    wr(0, 8'h0C); rd(1);
    chk("R12 poll ack", 32'({cap_ack, cap_line}), 32'({1'b1, 3'd5}));
    chk("R12 poll data", 32'(cap_rd), 32'h85);
    rd(1);
    chk("R12 poll consumed ack", 32'(cap_ack), 0);
    chk("R12 poll consumed data", 32'(cap_rd), 32'hA5);
    win_vld_i = 1'b0;
    wr(0, 8'h0C); rd(0);
    chk("R12 empty poll", 32'({cap_ack, cap_rd}), 0);
    rd(0); chk("R12 after empty poll", 32'(cap_rd), 32'h81);
  endtask

  task automatic t_ops;
    top_isr_vld_i = 1'b1; top_isr_line_i = 3'd6;
    wr(0, 8'h20); chk("R8 ns eoi clr", 32'(cap_clr), 32'h40);
    chk("R8 ns eoi rot kept", 32'(rot_base_o), 0);
    wr(0, 8'hA0); chk("R8 rot eoi clr", 32'(cap_clr), 32'h40);
    chk("R8 rot eoi base", 32'(rot_base_o), 7);
    top_isr_line_i = 3'd7;
    wr(0, 8'hA0); chk("R8 rot wrap", 32'({cap_clr, 5'd0, rot_base_o}), 32'h8000);
    top_isr_vld_i = 1'b0;
    wr(0, 8'hA0); chk("R8 empty isr", 32'({cap_clr, 5'd0, rot_base_o}), 0);
    wr(0, 8'h63); chk("R9 specific clr", 32'(cap_clr), 32'h08);
    chk("R9 specific rot kept", 32'(rot_base_o), 0);
    wr(0, 8'hE4); chk("R9 specific rot clr", 32'(cap_clr), 32'h10);
    chk("R9 specific rot base", 32'(rot_base_o), 5);
    wr(0, 8'hC7); chk("R10 set prio wrap", 32'({cap_clr, 5'd0, rot_base_o}), 0);
    wr(0, 8'hC2); chk("R10 set prio", 32'(rot_base_o), 3);
    wr(0, 8'h80); chk("R7 raeoi on", 32'(rot_aeoi_o), 1);
    wr(0, 8'h45);
    chk("R11 nop", 32'({cap_clr, mask_o, 3'd0, rot_aeoi_o, 1'b0, rot_base_o}), 32'h00A513);
    wr(0, 8'h00); chk("R7 raeoi off", 32'(rot_aeoi_o), 0);
  endtask

  task automatic t_init_full;
    wr(0, 8'h80); wr(0, 8'h0F); wr(0, 8'h68);
    wr(0, 8'h11);
    chk("R2 init pulse", 32'(cap_init), 1);
    chk("R2 cleared", 32'({mask_o, rot_base_o, rot_aeoi_o, spec_mask_o}), 0);
    chk("R2 busy single", 32'({init_busy_o, single_o}), 32'b10);
    wr(1, 8'h4D); chk("R3 vector", 32'(vec_base_o), 32'h48);
    chk("R4 to cascade", 32'(init_busy_o), 1);
    wr(1, 8'h00); chk("R4 cascade to mode", 32'({init_busy_o, mask_o}), 32'h100);
    wr(1, 8'h12); chk("R4 mode word", 32'({init_busy_o, sfnm_o, aeoi_o}), 32'b011);
    win_vld_i = 1'b1; win_line_i = 3'd3;
    rd(0); chk("R2 poll and select cleared", 32'({cap_ack, cap_rd}), 32'h81);
    win_vld_i = 1'b0;
  endtask

  task automatic t_init_single;
    wr(0, 8'h12); chk("R2 single, modes cleared", 32'({single_o, sfnm_o, aeoi_o}), 32'b100);
    wr(1, 8'h20); chk("R3 single no mode word", 32'({init_busy_o, vec_base_o}), 32'h020);
    wr(1, 8'h5A); chk("R5 mask after init", 32'(mask_o), 32'h5A);
    wr(0, 8'h13);
    wr(1, 8'hFF); chk("R3 single to mode", 32'({init_busy_o, vec_base_o}), 32'h1F8);
    wr(1, 8'h02); chk("R4 aeoi only", 32'({init_busy_o, sfnm_o, aeoi_o}), 32'b001);
  endtask

  task automatic t_init_cascade_short;
    wr(0, 8'h10);
    wr(1, 8'h08); chk("R4 cascade step", 32'(init_busy_o), 1);
    wr(1, 8'h33); chk("R5 no mask in sequence", 32'({init_busy_o, mask_o}), 0);
    wr(1, 8'h77); chk("R5 mask after short", 32'(mask_o), 32'h77);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mask_and_reads();
    t_spec_mask();
    t_poll();
    t_ops();
    t_init_full();
    t_init_single();
    t_init_cascade_short();
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule